// File: doc/BRIEF.md
# Paged Write Address Counter

This block tracks the word address of a serial write to a paged nonvolatile memory and stages the data in a one-page buffer. The serial engine reports three things: that a write transaction has started for this device, that a byte has arrived, and that the acknowledge slot for that byte has finished. The first byte after selection is the word address. The block loads it and answers with an acknowledge unless the addressed page is write-protected. Each later byte is acknowledged. When its acknowledge slot completes, the byte is stored at the current in-page offset, marked valid, and the offset then advances.

The offset counts modulo the page size and never carries into the page number. A long burst therefore wraps around the same page, and later bytes overwrite earlier ones. A STOP asks the write-cycle controller for a commit only when at least one data byte and its acknowledge have finished and no byte is partly received or still waiting for its acknowledge. Any other STOP drops the transaction and clears every valid flag. The write-cycle controller reads the staged bytes and their valid flags through a read port that uses the offset as its index.

Top module: `page_wr_addr_ctr`

## Requirements
- R1: After reset, `ack_o` and `commit_o` are 0, `addr_o` is 0, and `rd_vld_o` is 0 for every offset.
- R2: A byte that arrives as the first byte after `sel_i`, addressing a page that is not protected, is loaded into `addr_o` and drives `ack_o` to 1 in the cycle after `byte_vld_i`. The page is the upper `ADDR_W-4` bits of the address and the offset is the low 4 bits.
- R3: Each data byte whose acknowledge slot completes (`ack_done_i`) is written at the current offset, and its valid flag is set. The offset then increases by one, and the page bits do not change.
- R4: An offset of 15 wraps to 0 on the same page. A burst that starts at offset 10 and carries 12 bytes fills offsets 10 to 15 and then 0 to 5, and leaves the offset at 6.
- R5: When more than 16 data bytes are sent, each byte after the sixteenth replaces the byte stored earlier at the same offset.
- R6: A STOP that arrives after at least one complete data byte and its acknowledge, with no byte in progress, produces a one-cycle `commit_o` pulse in the next cycle. `commit_page_o` then holds the page number, and the valid flags stay set.
- R7: A STOP that arrives before any complete data byte, while `mid_byte_i` is high, or while a received byte still awaits its acknowledge, produces no commit and clears every valid flag.
- R8: If the word-address byte points at a protected page (`prot_en_i` high and page >= `prot_base_i`), it is not acknowledged. Every later byte of that transaction is not acknowledged and not stored, and its STOP produces no commit.
- R9: A byte that arrives while no transaction is open is not acknowledged and leaves `addr_o` unchanged.
- R10: Offsets that were not written in the transaction read back with `rd_vld_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Pulse: a write transaction addressed to this device has begun |
| stop_i | input | 1 | Pulse: STOP condition seen on the bus |
| mid_byte_i | input | 1 | High while a byte is partly shifted in |
| byte_vld_i | input | 1 | Pulse: a full byte is on `byte_i` |
| byte_i | input | 8 | Received byte |
| ack_done_i | input | 1 | Pulse: the acknowledge slot of the last byte has finished |
| prot_en_i | input | 1 | Enables write protection |
| prot_base_i | input | ADDR_W-4 | Lowest protected page |
| rd_off_i | input | 4 | Read index into the page buffer |
| ack_o | output | 1 | Acknowledge for the byte just received |
| addr_o | output | ADDR_W | Current word address (page and offset) |
| commit_o | output | 1 | One-cycle request to start the write cycle |
| commit_page_o | output | ADDR_W-4 | Page that the buffer belongs to |
| rd_data_o | output | 8 | Staged byte at `rd_off_i` |
| rd_vld_o | output | 1 | Valid flag at `rd_off_i` |

## Verification
The counter is driven with a short burst in the middle of a page and with a burst that starts at offset 10 and crosses the page end. The first separates a correct increment from a stuck or carrying one. The second shows whether the offset wraps or spills into the next page. An 18-byte burst shows whether overwriting replaces bytes in the right order. STOPs are sent with no data, in the middle of a byte, and with a byte still awaiting its acknowledge; this tells each discard path apart from a valid commit. Word addresses on either side of the protection boundary, plus bytes sent while no transaction is open, separate suppressing an acknowledge from accepting a byte.

// File: rtl/pwac_pkg.sv
// Package: shared types for the paged write address counter.
// Assumes: one transaction at a time; the engine orders its strobes.
package pwac_pkg;
    // Phases of one write transaction.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,  // no transaction open
        PH_WADDR = 3'd1,  // waiting for the word-address byte
        PH_WACK  = 3'd2,  // word address acknowledged, slot running
        PH_DATA  = 3'd3,  // ready for a data byte
        PH_DACK  = 3'd4,  // data byte held, acknowledge slot running
        PH_LOCK  = 3'd5   // protected target, ignore until STOP/select
    } phase_t;
endpackage

// File: rtl/pwac_addr_ctr.sv
// Module: pwac_addr_ctr
// Holds the word address as a page number and an in-page offset.
// A load writes both parts; an increment advances only the offset
// modulo the page size. The page never changes on an increment.
// Assumes: load and increment are never requested together.
module pwac_addr_ctr #(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 4,
    localparam int PAGE_W = ADDR_W - OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFF_W-1:0]  off_o
);
    localparam logic [OFF_W-1:0] OFF_ONE = OFF_W'(1);

    // Page register: changed by a load only.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            page_o <= '0;
        else if (load_i)
            page_o <= load_val_i[ADDR_W-1:OFF_W];
    end

    // Offset register: load, or advance with natural wrap of OFF_W bits.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            off_o <= '0;
        else if (load_i)
            off_o <= load_val_i[OFF_W-1:0];
        else if (inc_i)
            off_o <= off_o + OFF_ONE;
    end
endmodule

// File: rtl/pwac_page_buf.sv
// Module: pwac_page_buf
// One page of staged write data, with a valid flag for each byte.
// A write stores data and sets the flag at that offset; a clear drops
// all flags (the data is left in place and is meaningless without them).
// Assumes: clear takes priority over a write in the same cycle.
module pwac_page_buf #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 4,
    localparam int DEPTH = 1 << OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit;
        assign hit = we_i && (wr_off_i == OFF_W'(g));

        // Data slot: capture the byte when this offset is written.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                mem_q[g] <= '0;
            else if (hit && !clr_i)
                mem_q[g] <= wr_data_i;
        end

        // Valid flag: set on write, dropped on clear.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i || clr_i)
                vld_q[g] <= 1'b0;
            else if (hit)
                vld_q[g] <= 1'b1;
        end
    end

    // Read port: combinational lookup by offset.
    always_comb begin
        rd_data_o = mem_q[rd_off_i];
        rd_vld_o  = vld_q[rd_off_i];
    end
endmodule

// File: rtl/pwac_seq.sv
// Module: pwac_seq
// Sequences one write transaction: word address, then data bytes,
// then STOP. Drives the acknowledge, the address load and increment,
// the buffer write and clear, and the commit request.
// Assumes: sel_i and stop_i never coincide with each other.
module pwac_seq
    import pwac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              sel_i,
    input  logic              stop_i,
    input  logic              mid_byte_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              ack_done_i,
    input  logic              prot_hit_i,
    output logic              ack_o,
    output logic              commit_o,
    output logic              addr_ld_o,
    output logic              buf_we_o,
    output logic              buf_clr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              lock_o
);
    phase_t ph_q;
    logic   got_byte_q;
    logic   stop_ok;
    logic   quiet;

    // No select or STOP this cycle: the phase logic below may act.
    assign quiet   = !sel_i && !stop_i;
    // A STOP may commit only from the data phase after a full byte.
    assign stop_ok = (ph_q == PH_DATA) && got_byte_q && !mid_byte_i;

    // Strobes decoded from the current phase and the engine inputs.
    always_comb begin
        addr_ld_o = quiet && (ph_q == PH_WADDR) && byte_vld_i && !prot_hit_i;
        buf_we_o  = quiet && (ph_q == PH_DACK) && ack_done_i;
        buf_clr_o = sel_i || (stop_i && !stop_ok);
        lock_o    = (ph_q == PH_LOCK);
    end

    // Phase, acknowledge and commit registers.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            ph_q       <= PH_IDLE;
            ack_o      <= 1'b0;
            commit_o   <= 1'b0;
            got_byte_q <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            if (sel_i) begin
                ph_q       <= PH_WADDR;
                ack_o      <= 1'b0;
                got_byte_q <= 1'b0;
            end else if (stop_i) begin
                ph_q     <= PH_IDLE;
                ack_o    <= 1'b0;
                commit_o <= stop_ok;
            end else begin
                unique case (ph_q)
                    PH_WADDR: if (byte_vld_i) begin
                        ph_q  <= prot_hit_i ? PH_LOCK : PH_WACK;
                        ack_o <= !prot_hit_i;
                    end
                    PH_WACK: if (ack_done_i) begin
                        ph_q  <= PH_DATA;
                        ack_o <= 1'b0;
                    end
                    PH_DATA: if (byte_vld_i) begin
                        ph_q  <= PH_DACK;
                        ack_o <= 1'b1;
                    end
                    PH_DACK: if (ack_done_i) begin
                        ph_q       <= PH_DATA;
                        ack_o      <= 1'b0;
                        got_byte_q <= 1'b1;
                    end
                    default: ack_o <= 1'b0;
                endcase
            end
        end
    end

    // Pending data byte: held from its arrival until its slot completes.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            wr_data_o <= '0;
        else if (quiet && (ph_q == PH_DATA) && byte_vld_i)
            wr_data_o <= byte_i;
    end
endmodule

// File: rtl/page_wr_addr_ctr.sv
// Module: page_wr_addr_ctr (top)
// Word-address tracking and page staging for serial writes. It joins the
// sequencer, the wrapping address counter and the page buffer, and
// decides whether the incoming word address falls in the protected range.
// Assumes: ADDR_W <= DATA_W (the word address fits in one byte).
module page_wr_addr_ctr #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              sel_i,
    input  logic              stop_i,
    input  logic              mid_byte_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              ack_done_i,
    input  logic              prot_en_i,
    input  logic [PAGE_W-1:0] prot_base_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic              ack_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              commit_o,
    output logic [PAGE_W-1:0] commit_page_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o
);
    logic [ADDR_W-1:0] waddr;
    logic              prot_hit;
    logic              addr_ld;
    logic              buf_we;
    logic              buf_clr;
    logic              lock;
    logic [DATA_W-1:0] wr_data;
    logic [PAGE_W-1:0] cur_page;
    logic [OFF_W-1:0]  cur_off;

    // Protection decision on the page field of the incoming address byte.
    always_comb begin
        waddr    = byte_i[ADDR_W-1:0];
        prot_hit = prot_en_i && (waddr[ADDR_W-1:OFF_W] >= prot_base_i);
    end

    pwac_seq #(.DATA_W(DATA_W)) u_seq (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .sel_i      (sel_i),
        .stop_i     (stop_i),
        .mid_byte_i (mid_byte_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .ack_done_i (ack_done_i),
        .prot_hit_i (prot_hit),
        .ack_o      (ack_o),
        .commit_o   (commit_o),
        .addr_ld_o  (addr_ld),
        .buf_we_o   (buf_we),
        .buf_clr_o  (buf_clr),
        .wr_data_o  (wr_data),
        .lock_o     (lock)
    );

    pwac_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .load_i     (addr_ld),
        .load_val_i (waddr),
        .inc_i      (buf_we),
        .page_o     (cur_page),
        .off_o      (cur_off)
    );

    pwac_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .clr_i     (buf_clr),
        .we_i      (buf_we),
        .wr_off_i  (cur_off),
        .wr_data_i (wr_data),
        .rd_off_i  (rd_off_i),
        .rd_data_o (rd_data_o),
        .rd_vld_o  (rd_vld_o)
    );

    // Address and commit page outputs.
    always_comb begin
        addr_o        = {cur_page, cur_off};
        commit_page_o = cur_page;
    end
endmodule

// File: rtl/pwac_chk.sv
// Module: pwac_chk
// Assertion checker for page_wr_addr_ctr, attached by bind below.
module pwac_chk #(
    parameter int OFF_W  = 4,
    parameter int PAGE_W = 4
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              stop_i,
    input logic              mid_byte_i,
    input logic              ack_o,
    input logic              commit_o,
    input logic              buf_we,
    input logic              lock,
    input logic [OFF_W-1:0]  cur_off,
    input logic [PAGE_W-1:0] cur_page
);
    localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

    a_r3_offset_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        buf_we |=> (cur_off == $past(cur_off) + ONE));

    a_r3_page_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        buf_we |=> $stable(cur_page));

    a_r4_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (buf_we && (cur_off == '1)) |=> (cur_off == '0));

    a_r6_commit_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        commit_o |=> !commit_o);

    a_r6_commit_after_stop: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(commit_o) |-> $past(stop_i));

    a_r7_no_commit_midbyte: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (stop_i && mid_byte_i) |=> !commit_o);

    a_r8_locked_no_ack: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        lock |-> !ack_o);
endmodule

bind page_wr_addr_ctr pwac_chk #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_pwac_chk (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .stop_i     (stop_i),
    .mid_byte_i (mid_byte_i),
    .ack_o      (ack_o),
    .commit_o   (commit_o),
    .buf_we     (buf_we),
    .lock       (lock),
    .cur_off    (cur_off),
    .cur_page   (cur_page)
);

// File: tb/test_page_wr_addr_ctr.sv
// Directed bench for page_wr_addr_ctr: one task per scenario.
module test_page_wr_addr_ctr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 0, stop = 0, mid = 0, bvld = 0, adone = 0, pen = 0;
    logic [7:0] bval = 0;
    logic [3:0] pbase = 0, roff = 0;
    logic       ack, commit, rvld;
    logic [7:0] addr, rdat;
    logic [3:0] cpage;
    int         n_run = 0, n_fail = 0;
    logic [7:0] exp_d [16];
    logic       exp_v [16];

    always #4 clk = ~clk;  // 125 MHz

    page_wr_addr_ctr i_page_wr_addr_ctr (
        .clk_i(clk), .rst_n_i(rst_n), .sel_i(sel), .stop_i(stop),
        .mid_byte_i(mid), .byte_vld_i(bvld), .byte_i(bval),
        .ack_done_i(adone), .prot_en_i(pen), .prot_base_i(pbase),
        .rd_off_i(roff), .ack_o(ack), .addr_o(addr), .commit_o(commit),
        .commit_page_o(cpage), .rd_data_o(rdat), .rd_vld_o(rvld)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_model();
        for (int i = 0; i < 16; i++) begin exp_v[i] = 0; exp_d[i] = 0; end
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic open_xfer();
        sel = 1; cyc(); sel = 0; clr_model();
    endtask

    // Send one byte; return the acknowledge seen; complete its slot.
    task automatic send(input logic [7:0] b, output logic a);
        bval = b; bvld = 1; cyc(); bvld = 0;
        a = ack;
        adone = 1; cyc(); adone = 0;
    endtask

    task automatic do_stop(input logic m, output logic c);
        mid = m; stop = 1; cyc(); stop = 0; mid = 0;
        c = commit;
    endtask

    task automatic check_buf(string req);
        for (int i = 0; i < 16; i++) begin
            roff = 4'(i); #1;
            chk(req, int'(rvld), int'(exp_v[i]));
            if (exp_v[i]) chk(req, int'(rdat), int'(exp_d[i]));
        end
    endtask

    // Write n bytes starting at address a0, tracking the model.
    task automatic burst(input logic [7:0] a0, input int n, input logic [7:0] seed,
                         string req);
        logic a;
        logic [3:0] o;
        open_xfer();
        send(a0, a);
        chk("R2 addr ack", int'(a), 1);
        chk("R2 addr load", int'(addr), int'(a0));
        o = a0[3:0];
        for (int i = 0; i < n; i++) begin
            send(seed + 8'(i), a);
            chk(req, int'(a), 1);
            exp_d[o] = seed + 8'(i); exp_v[o] = 1; o = o + 4'd1;
        end
        chk("R3 page held", int'(addr[7:4]), int'(a0[7:4]));
        chk(req, int'(addr[3:0]), int'(o));
    endtask

    task automatic t_reset();
        chk("R1 ack", int'(ack), 0);
        chk("R1 commit", int'(commit), 0);
        chk("R1 addr", int'(addr), 0);
        clr_model();
        check_buf("R1 flags");
    endtask

    task automatic t_short();
        logic c;
        burst(8'h24, 3, 8'h11, "R3 increment");
        check_buf("R10 unwritten offsets");
        do_stop(0, c);
        chk("R6 commit", int'(c), 1);
        chk("R6 page", int'(cpage), 2);
        cyc();
        chk("R6 single pulse", int'(commit), 0);
        check_buf("R6 flags kept");
    endtask

    task automatic t_wrap();
        logic c;
        burst(8'h3A, 12, 8'h40, "R4 wrap");
        chk("R4 end offset", int'(addr), 'h36);
        check_buf("R4 wrapped contents");
        do_stop(0, c);
        chk("R6 commit after wrap", int'(c), 1);
    endtask

    task automatic t_over();
        logic c;
        burst(8'h50, 18, 8'h80, "R5 overwrite");
        chk("R5 end offset", int'(addr), 'h52);
        chk("R5 slot0", int'(exp_d[0]), 'h90);
        check_buf("R5 newer bytes kept");
        do_stop(0, c);
        chk("R5 commit", int'(c), 1);
    endtask

    task automatic t_early();
        logic a, c;
        open_xfer(); send(8'h61, a);
        do_stop(0, c);
        chk("R7 no data stop", int'(c), 0);
        burst(8'h70, 2, 8'h01, "R3 increment");
        do_stop(1, c);
        chk("R7 mid byte stop", int'(c), 0);
        clr_model(); check_buf("R7 flags cleared");
        burst(8'h70, 1, 8'h05, "R3 increment");
        bval = 8'h77; bvld = 1; cyc(); bvld = 0;
        do_stop(0, c);
        chk("R7 pending ack stop", int'(c), 0);
        clr_model(); check_buf("R7 flags cleared");
    endtask

    task automatic t_prot();
        logic a, c;
        pen = 1; pbase = 4'd9;
        burst(8'h83, 1, 8'hA0, "R8 page below base");
        do_stop(0, c);
        chk("R8 below base commit", int'(c), 1);
        open_xfer(); clr_model();
        send(8'h95, a);
        chk("R8 addr nack", int'(a), 0);
        chk("R8 addr kept", int'(addr), 'h84);
        send(8'h33, a);
        chk("R8 data nack", int'(a), 0);
        chk("R8 no increment", int'(addr), 'h84);
        do_stop(0, c);
        chk("R8 no commit", int'(c), 0);
        check_buf("R8 nothing stored");
        pen = 0;
    endtask

    task automatic t_idle();
        logic a;
        send(8'h12, a);
        chk("R9 idle nack", int'(a), 0);
        chk("R9 addr unchanged", int'(addr), 'h84);
    endtask

    initial begin
        fork
            begin
                cyc(); cyc(); cyc();
                t_reset();
                rst_n = 1; cyc();
                t_reset();
                t_short();
                t_wrap();
                t_over();
                t_early();
                t_prot();
                t_idle();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule